// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block owns the floating-point status and control word of a processor core. It keeps five exception kinds in three groups: the sticky flags, the trap enables and the per-operation causes. It also keeps two mode bits, one that selects the active register bank and one that selects the transfer size. Two decoded toggle strobes flip the mode bits in a single cycle. A full load of the word from the integer side instead runs as a fixed multi-cycle sequence, and the block holds the core stalled through `busy_o` for that whole sequence.

On every floating-point operation the cause field is rewritten with that operation's raised exceptions, and the same bits are ORed into the sticky flags. A vector-transform operation always raises inexact, because it never detects that condition. It also requests a trap whenever the invalid-operation enable is set, because its operands cannot be screened beforehand. A trap request is a one-cycle pulse. It carries a kind code chosen by fixed priority.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset, `stat_o` is 0, FR and SZ are 0, and `busy_o`, `trap_o` and `trap_kind_o` are 0.
- R2: A bank-toggle strobe accepted while not busy inverts FR (`stat_o` bit 21, also `fr_o`) at the next clock edge.
- R3: A size-toggle strobe accepted while not busy inverts SZ (`stat_o` bit 20, also `sz_o`) at the next clock edge. Both toggles may act in the same cycle.
- R4: A load accepted while idle raises `busy_o` for exactly 5 cycles. The loaded word becomes visible in the cycle `busy_o` falls. Only bits 21:20 and 14:0 are stored, and all other bits read 0.
- R5: A load issued while busy waits and starts at once when the current load commits. If several loads are issued during one busy window, only the last one is kept.
- R6: While `busy_o` is high, the toggle, operation and transform strobes have no effect on `stat_o` or `trap_o`.
- R7: An accepted operation replaces the cause field (bits 14:10) with its raised set and ORs that set into the sticky flags (bits 4:0). Bit order within each field is: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid. Enables sit in bits 9:5, in the same order.
- R8: An accepted transform sets the inexact bit in both the cause field and the flag field, whatever the other causes are.
- R9: `trap_o` rises one cycle after an accepted operation whose raised set intersects the enables. A transform with the inexact enable set therefore always traps.
- R10: A transform with the invalid enable set traps with kind invalid, even when the invalid cause is not raised.
- R11: `trap_kind_o` names the highest-priority trapping exception. The codes are 5 invalid, 4 divide-by-zero, 3 overflow, 2 underflow, 1 inexact and 0 none, and the priority follows that same order.
- R12: `trap_o` is a single-cycle pulse. It is low in any cycle that does not follow an accepted trapping operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tog_bank_i | input | 1 | Bank-toggle strobe |
| tog_size_i | input | 1 | Size-toggle strobe |
| ld_i | input | 1 | Full-word load strobe |
| ld_data_i | input | 32 | Word to load |
| fpop_i | input | 1 | A floating-point operation executes |
| xform_i | input | 1 | A vector-transform operation executes |
| exc_cause_i | input | 5 | Exceptions raised by the executing operation |
| stat_o | output | 32 | Current status and control word |
| fr_o | output | 1 | Active bank select |
| sz_o | output | 1 | Transfer size select |
| busy_o | output | 1 | Load in progress, stall the core |
| trap_o | output | 1 | Exception trap request pulse |
| trap_kind_o | output | 3 | Kind of the requested trap |

## Verification
The bench sweeps every enable pattern against every cause pattern, for both plain operations and transforms. This catches a priority encoder that picks the lowest bit, flags that are overwritten instead of accumulated, and a transform that skips the forced inexact bit or the forced invalid trap. Back-to-back loads in one busy window expose a sequencer that drops the waiting load, keeps the first one instead of the last, or gets the stall length wrong by a cycle. Strobes driven during the stall show whether a design lets the stalled core corrupt the word that is about to be committed.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int REG_W    = 32;
  localparam int XW       = 5;
  localparam int FLG_LO   = 0;
  localparam int EN_LO    = 5;
  localparam int CA_LO    = 10;
  localparam int SZ_POS   = 20;
  localparam int FR_POS   = 21;
  localparam int X_INEXACT = 0;
  localparam int X_INVALID = 4;

  typedef enum logic [2:0] {
    TK_NONE    = 3'd0,
    TK_INEXACT = 3'd1,
    TK_UNDER   = 3'd2,
    TK_OVER    = 3'd3,
    TK_DIVZ    = 3'd4,
    TK_INVAL   = 3'd5
  } trap_kind_e;

  typedef struct packed {
    logic          fr;
    logic          sz;
    logic [XW-1:0] en;
    logic [XW-1:0] flg;
    logic [XW-1:0] ca;
  } fpsr_t;

  function automatic logic [REG_W-1:0] fpsr_pack(input fpsr_t s);
    logic [REG_W-1:0] r;
    r = '0;
    r[FLG_LO +: XW] = s.flg;
    r[EN_LO  +: XW] = s.en;
    r[CA_LO  +: XW] = s.ca;
    r[SZ_POS]       = s.sz;
    r[FR_POS]       = s.fr;
    return r;
  endfunction

  function automatic fpsr_t fpsr_unpack(input logic [REG_W-1:0] w);
    fpsr_t s;
    s.flg = w[FLG_LO +: XW];
    s.en  = w[EN_LO  +: XW];
    s.ca  = w[CA_LO  +: XW];
    s.sz  = w[SZ_POS];
    s.fr  = w[FR_POS];
    return s;
  endfunction

  // Highest set bit wins; code is its index plus one.
  function automatic trap_kind_e top_kind(input logic [XW-1:0] hit);
    trap_kind_e k;
    k = TK_NONE;
    for (int i = 0; i < XW; i++) begin
      if (hit[i]) k = trap_kind_e'(3'(i + 1));
    end
    return k;
  endfunction

  function automatic logic [XW-1:0] raised_set(input logic [XW-1:0] cause,
                                               input logic is_xform);
    logic [XW-1:0] r;
    r = cause;
    if (is_xform) r[X_INEXACT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fpsr_load_seq.sv
module fpsr_load_seq #(
  parameter int LOAD_CYCLES = 5,
  parameter int W           = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic         busy_o,
  output logic         start_o,
  output logic         commit_o,
  output logic [W-1:0] commit_data_o
);
  localparam int CW = $clog2(LOAD_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  hold_q;
  logic          pend_q;
  logic [W-1:0]  pend_data_q;

  assign busy_o        = (cnt_q != '0);
  assign commit_o      = busy_o && (cnt_q == CW'(1));
  assign commit_data_o = hold_q;
  assign start_o       = (ld_i && !busy_o) || (commit_o && (ld_i || pend_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      hold_q      <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else if (!busy_o) begin
      if (ld_i) begin
        cnt_q  <= CW'(LOAD_CYCLES);
        hold_q <= ld_data_i;
      end
    end else if (commit_o) begin
      if (ld_i) begin
        cnt_q  <= CW'(LOAD_CYCLES);
        hold_q <= ld_data_i;
        pend_q <= 1'b0;
      end else if (pend_q) begin
        cnt_q  <= CW'(LOAD_CYCLES);
        hold_q <= pend_data_q;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= cnt_q - CW'(1);
      if (ld_i) begin
        pend_q      <= 1'b1;
        pend_data_q <= ld_data_i;
      end
    end
  end
endmodule

// File: rtl/fpsr_exc_unit.sv
module fpsr_exc_unit
  import fpsr_pkg::*;
(
  input  logic          op_go_i,
  input  logic          is_xform_i,
  input  logic [XW-1:0] cause_i,
  input  logic [XW-1:0] en_i,
  output logic [XW-1:0] new_cause_o,
  output logic          trap_hit_o,
  output trap_kind_e    trap_kind_o
);
  logic [XW-1:0] hit;

  always_comb begin
    new_cause_o = raised_set(cause_i, is_xform_i);
    hit         = new_cause_o & en_i;
    if (is_xform_i && en_i[X_INVALID]) hit[X_INVALID] = 1'b1;
    trap_hit_o  = op_go_i && (hit != '0);
    trap_kind_o = op_go_i ? top_kind(hit) : TK_NONE;
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter int LOAD_CYCLES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tog_bank_i,
  input  logic        tog_size_i,
  input  logic        ld_i,
  input  logic [31:0] ld_data_i,
  input  logic        fpop_i,
  input  logic        xform_i,
  input  logic [4:0]  exc_cause_i,
  output logic [31:0] stat_o,
  output logic        fr_o,
  output logic        sz_o,
  output logic        busy_o,
  output logic        trap_o,
  output logic [2:0]  trap_kind_o
);
  fpsr_t         st_q;
  logic          busy_w;
  logic          start_w;
  logic          commit_w;
  logic [31:0]   commit_data_w;
  logic          op_go_w;
  logic [XW-1:0] new_cause_w;
  logic          trap_hit_w;
  trap_kind_e    kind_w;
  logic          trap_q;
  trap_kind_e    kind_q;
  fpsr_t         commit_st_w;

  fpsr_load_seq #(.LOAD_CYCLES(LOAD_CYCLES), .W(REG_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_i          (ld_i),
    .ld_data_i     (ld_data_i),
    .busy_o        (busy_w),
    .start_o       (start_w),
    .commit_o      (commit_w),
    .commit_data_o (commit_data_w)
  );

  assign op_go_w     = (fpop_i || xform_i) && !busy_w;
  assign commit_st_w = fpsr_unpack(commit_data_w);

  fpsr_exc_unit u_exc (
    .op_go_i     (op_go_w),
    .is_xform_i  (xform_i),
    .cause_i     (exc_cause_i),
    .en_i        (st_q.en),
    .new_cause_o (new_cause_w),
    .trap_hit_o  (trap_hit_w),
    .trap_kind_o (kind_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      trap_q <= 1'b0;
      kind_q <= TK_NONE;
    end else begin
      trap_q <= trap_hit_w;
      kind_q <= kind_w;
      if (commit_w) begin
        st_q <= commit_st_w;
      end else if (!busy_w) begin
        if (tog_bank_i) st_q.fr <= ~st_q.fr;
        if (tog_size_i) st_q.sz <= ~st_q.sz;
        if (op_go_w) begin
          st_q.ca  <= new_cause_w;
          st_q.flg <= st_q.flg | new_cause_w;
        end
      end
    end
  end

  assign stat_o      = fpsr_pack(st_q);
  assign fr_o        = st_q.fr;
  assign sz_o        = st_q.sz;
  assign busy_o      = busy_w;
  assign trap_o      = trap_q;
  assign trap_kind_o = kind_q;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk #(
  parameter int LOAD_CYCLES = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tog_bank_i,
  input logic        tog_size_i,
  input logic        xform_i,
  input logic [31:0] stat_o,
  input logic        fr_o,
  input logic        sz_o,
  input logic        busy_o,
  input logic        trap_o,
  input logic [2:0]  trap_kind_o,
  input logic        op_go_w,
  input logic        start_w,
  input logic        commit_w
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (start_w) run_len <= '0;
    else if (busy_o)  run_len <= run_len + 16'd1;
  end

  a_r2_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_bank_i && !busy_o) |=> (fr_o != $past(fr_o)));

  a_r3_size_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_size_i && !busy_o) |=> (sz_o != $past(sz_o)));

  a_r4_load_length: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |-> (run_len == 16'(LOAD_CYCLES - 1)));

  a_r6_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !commit_w) |=> $stable(stat_o));

  a_r8_xform_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (xform_i && !busy_o) |=> (stat_o[10] && stat_o[0]));

  a_r10_xform_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (xform_i && !busy_o && stat_o[9]) |=> (trap_o && trap_kind_o == 3'd5));

  a_r12_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(op_go_w));

  a_r11_kind_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_kind_o != 3'd0 && trap_kind_o <= 3'd5));
endmodule

bind fpsr_ctrl fpsr_ctrl_chk #(.LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tog_bank_i  (tog_bank_i),
  .tog_size_i  (tog_size_i),
  .xform_i     (xform_i),
  .stat_o      (stat_o),
  .fr_o        (fr_o),
  .sz_o        (sz_o),
  .busy_o      (busy_o),
  .trap_o      (trap_o),
  .trap_kind_o (trap_kind_o),
  .op_go_w     (op_go_w),
  .start_w     (start_w),
  .commit_w    (commit_w)
);

// File: tb/test_fpsr_ctrl.sv
module test_fpsr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tog_bank_i = 1'b0, tog_size_i = 1'b0, ld_i = 1'b0;
  logic [31:0] ld_data_i = '0;
  logic        fpop_i = 1'b0, xform_i = 1'b0;
  logic [4:0]  exc_cause_i = '0;
  logic [31:0] stat_o;
  logic        fr_o, sz_o, busy_o, trap_o;
  logic [2:0]  trap_kind_o;

  int n_chk = 0, n_bad = 0;
  logic       e_fr = 0, e_sz = 0;
  logic [4:0] e_en = 0, e_fl = 0, e_ca = 0;

  always #10 clk = ~clk;

  fpsr_ctrl i_fpsr_ctrl (.*);

  function automatic logic [31:0] mk(logic fr, logic sz, logic [4:0] en,
                                     logic [4:0] fl, logic [4:0] ca);
    return (32'(fr) << 21) | (32'(sz) << 20) | (32'(ca) << 10) |
           (32'(en) << 5) | 32'(fl);
  endfunction

  function automatic logic [2:0] prio(logic [4:0] h);
    if (h[4]) return 3'd5;
    if (h[3]) return 3'd4;
    if (h[2]) return 3'd3;
    if (h[1]) return 3'd2;
    if (h[0]) return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_stat(string req);
    chk(req, stat_o, mk(e_fr, e_sz, e_en, e_fl, e_ca));
  endtask

  // Single load from idle; optionally drive strobes during the stall (R6).
  task automatic do_load(logic [31:0] d, bit poke);
    @(negedge clk); ld_i = 1; ld_data_i = d;
    @(negedge clk); ld_i = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R4 busy", 32'(busy_o), 32'd1);
      if (poke) begin
        tog_bank_i = 1; tog_size_i = 1; fpop_i = 1; exc_cause_i = 5'h1f;
      end
      @(negedge clk);
      tog_bank_i = 0; tog_size_i = 0; fpop_i = 0; exc_cause_i = 0;
    end
    chk("R4 busy fall", 32'(busy_o), 32'd0);
    e_fr = d[21]; e_sz = d[20]; e_ca = d[14:10]; e_en = d[9:5]; e_fl = d[4:0];
    chk_stat(poke ? "R6 stall ignore" : "R4 load value");
    if (poke) chk("R6 no trap", 32'(trap_o), 32'd0);
  endtask

  task automatic do_op(logic xf, logic [4:0] c);
    logic [4:0] r, h;
    @(negedge clk); fpop_i = !xf; xform_i = xf; exc_cause_i = c;
    @(negedge clk); fpop_i = 0; xform_i = 0; exc_cause_i = 0;
    r = c | {4'b0, xf};
    h = r & e_en;
    if (xf && e_en[4]) h[4] = 1'b1;
    e_ca = r; e_fl = e_fl | r;
    chk(xf ? "R8 xform word" : "R7 op word", stat_o, mk(e_fr, e_sz, e_en, e_fl, e_ca));
    chk(xf ? "R10 trap" : "R9 trap", 32'(trap_o), 32'(h != 0));
    chk("R11 kind", 32'(trap_kind_o), 32'(prio(h)));
    @(negedge clk);
    chk("R12 pulse", 32'(trap_o), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_stat("R1 reset word");
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 trap", {29'(trap_o), trap_kind_o}, 0);
    rst_n = 1;
    @(negedge clk);

    tog_bank_i = 1; @(negedge clk); tog_bank_i = 0; e_fr = 1;
    chk("R2 fr", 32'(fr_o), 1); chk_stat("R2 word");
    tog_size_i = 1; @(negedge clk); tog_size_i = 0; e_sz = 1;
    chk("R3 sz", 32'(sz_o), 1); chk_stat("R3 word");
    tog_bank_i = 1; tog_size_i = 1; @(negedge clk);
    tog_bank_i = 0; tog_size_i = 0; e_fr = 0; e_sz = 0;
    chk_stat("R3 both toggles");

    do_load(32'hFFFF_FFFF, 0);
    chk("R4 reserved zero", stat_o, 32'h0030_7FFF);
    do_load(32'h0000_0000, 1);
    do_load(32'h0010_2A55, 1);

    // R5: two loads during one busy window; last one wins.
    @(negedge clk); ld_i = 1; ld_data_i = 32'h0020_03E0;
    @(negedge clk); ld_i = 0;
    @(negedge clk); ld_i = 1; ld_data_i = 32'h0000_001F;
    @(negedge clk); ld_i = 1; ld_data_i = 32'h0030_4C21;
    @(negedge clk); ld_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 first commit", stat_o, 32'h0020_03E0);
    chk("R5 chained busy", 32'(busy_o), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 chained busy", 32'(busy_o), 1);
    end
    @(negedge clk);
    chk("R5 last wins", stat_o, 32'h0030_4C21);
    chk("R5 idle", 32'(busy_o), 0);

    for (int en = 0; en < 32; en++) begin
      do_load(mk(0, 0, 5'(en), 0, 0), 0);
      for (int c = 0; c < 32; c++) do_op(0, 5'(c));
      for (int c = 0; c < 32; c++) do_op(1, 5'(c));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule